// File: doc/BRIEF.md
# Fixed Off-Time H-Bridge Current Chopper

This block regulates the current in one H-bridge winding. In internal mode it turns the bridge on in the direction chosen by the phase bit. It ignores the current-trip comparator for a short blanking window after each turn-on. Once the comparator trips, it holds the bridge in decay for a fixed, programmable off time and then turns the bridge on again. The decay can be pure slow decay, with both low sides on. It can also be mixed decay, where a programmable stretch of fast decay, using the opposite diagonal, comes first and slow decay fills the rest of the off time.

A low level on the enable pin overrides the chopper and forces the bridge into decay. Whether that decay is fast or slow is set by its own configuration bit. A rising edge on enable restarts the drive. When synchronous rectification is enabled, a zero-current detect that fires during fast decay switches all four FETs off until that fast-decay window ends. When synchronous rectification is disabled, fast decay leaves every FET off so that the external diodes carry the current. A zero current code, or mode fields that have not yet been written, keeps all four gates low.

The trip comparator is asynchronous and passes through a two-flop synchronizer. The gate stage never moves straight from one non-zero gate pattern to another: it always inserts at least one all-off clock between them.

Top module: `chopper_core`

## Requirements
- R1: The trip input is synchronized through two flops. A trip therefore reaches the gates four clocks after it is applied, and the fourth clock shows all-off. After each turn-on, trip is ignored for 4, 6, 12 or 24 clocks for `blank_sel` = 0, 1, 2 or 3. With trip held high, each drive pulse seen at the gates (after a dead clock) therefore lasts exactly that many clocks.
- R2: A trip starts an off time of 8*(1+`toff_n`)-1 clocks. This count includes the dead clocks seen at the gates. After it, drive resumes.
- R3: With `int_slow`=0 (mixed decay), fast decay lasts 8*(1+`tfd_n`)-1 clocks from the trip, then slow decay runs for the rest of the off time. If the fast time is not shorter than the off time, fast decay fills the whole off time.
- R4: With `int_slow`=1, the whole off time is slow decay.
- R5: The gate bus is {ah,al,bh,bl}. With `phase`=1, drive is 1001 and fast decay is 0110. With `phase`=0, drive is 0110 and fast decay is 1001. Slow decay is always 0101.
- R6: The high and low gates of one leg are never on together. Between two different non-zero patterns there is at least one all-off clock.
- R7: While `en` is low, the bridge decays: fast when `ext_slow`=0, slow when `ext_slow`=1. Changes to `ext_slow` take effect while `en` is low. When `en` rises, drive is restored with a new blanking window.
- R8: With `sr_en`=1, `zero_det` high during fast decay switches all gates off. In internal mode this lasts until the fast window ends. In external mode it lasts until `en` rises or slow decay is selected.
- R9: With `sr_en`=0, fast decay drives all gates off. In mixed decay, the gates then go directly from all-off to slow decay.
- R10: All gates are off during reset, and within two clocks after `cfg_ready`=0 or `dac_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_raw | input | 1 | Asynchronous current-trip comparator |
| zero_det | input | 1 | Zero/reverse-current detect (synchronous) |
| en | input | 1 | High: internal chopping; low: forced decay |
| cfg_ready | input | 1 | Mode fields have been written |
| blank_sel | input | 2 | Blanking length code |
| toff_n | input | 5 | Off-time field |
| tfd_n | input | 4 | Fast-decay-time field |
| int_slow | input | 1 | Internal decay: 0 mixed, 1 slow |
| ext_slow | input | 1 | Forced decay: 0 fast, 1 slow |
| phase | input | 1 | Current direction: 1 forward, 0 reverse |
| dac_code | input | 4 | Current code; 0 disables the bridge |
| sr_en | input | 1 | Synchronous rectification enable |
| gate_ah | output | 1 | Leg A high-side gate |
| gate_al | output | 1 | Leg A low-side gate |
| gate_bh | output | 1 | Leg B high-side gate |
| gate_bl | output | 1 | Leg B low-side gate |

## Verification
The assertions check four properties on every cycle: no leg ever shoots through, an all-off clock separates any two different patterns, the gates are off once the bridge has been disabled for two clocks, and drive never appears after `en` has been low for two clocks. The bench's scenarios measure the run lengths of the patterns at the gates. These show behaviour that no single-cycle property captures: each blanking code, the off and fast-decay lengths, the mixed, slow and diode-decay sequences, the synchronizer latency, and the cut-off caused by the zero-current detect.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRIVE, ST_FAST, ST_CUT, ST_SLOW, ST_XFAST, ST_XCUT, ST_XSLOW
  } chop_state_e;

  // gate bus order {ah, al, bh, bl}
  localparam logic [3:0] PAT_OFF  = 4'b0000;
  localparam logic [3:0] PAT_FWD  = 4'b1001;
  localparam logic [3:0] PAT_REV  = 4'b0110;
  localparam logic [3:0] PAT_SLOW = 4'b0101;

  function automatic logic [4:0] blank_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd6;
      2'd2:    return 5'd12;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int FD_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             trip_s,
  input  logic             zero_det,
  input  logic             en,
  input  logic             sr_en,
  input  logic             int_slow,
  input  logic             ext_slow,
  input  logic [1:0]       blank_sel,
  input  logic [OFF_W-1:0] toff_n,
  input  logic [FD_W-1:0]  tfd_n,
  output chop_state_e      state
);
  localparam int CNT_W = OFF_W + 3;

  chop_state_e      nxt;
  logic             ld_blank, ld_decay;
  logic [CNT_W-1:0] blank_cnt, off_cnt, fd_cnt;
  chop_state_e      ext_pick;

  assign ext_pick = ext_slow ? ST_XSLOW : ST_XFAST;

  always_comb begin
    nxt      = state;
    ld_blank = 1'b0;
    ld_decay = 1'b0;
    if (!active) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (en) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
          else    nxt = ext_slow ? ST_XSLOW : ST_XCUT;
        end
        ST_DRIVE: begin
          if (!en) nxt = ext_pick;
          else if (blank_cnt == '0 && trip_s) begin
            ld_decay = 1'b1;
            nxt      = int_slow ? ST_SLOW : ST_FAST;
          end
        end
        ST_FAST, ST_CUT: begin
          if (!en) nxt = ext_pick;
          else if (off_cnt == '0) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
          else if (fd_cnt == '0) nxt = ST_SLOW;
          else if (state == ST_FAST && sr_en && zero_det) nxt = ST_CUT;
        end
        ST_SLOW: begin
          if (!en) nxt = ext_pick;
          else if (off_cnt == '0) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
        end
        ST_XFAST: begin
          if (en) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
          else if (ext_slow) nxt = ST_XSLOW;
          else if (sr_en && zero_det) nxt = ST_XCUT;
        end
        ST_XCUT: begin
          if (en) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
          else if (ext_slow) nxt = ST_XSLOW;
        end
        default: begin
          if (en) begin nxt = ST_DRIVE; ld_blank = 1'b1; end
          else if (!ext_slow) nxt = ST_XFAST;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      blank_cnt <= '0;
      off_cnt   <= '0;
      fd_cnt    <= '0;
    end else begin
      state <= nxt;
      if (ld_blank)            blank_cnt <= CNT_W'(blank_len(blank_sel));
      else if (blank_cnt != 0) blank_cnt <= blank_cnt - 1'b1;
      if (ld_decay) begin
        off_cnt <= {toff_n, 3'b110};
        fd_cnt  <= CNT_W'({tfd_n, 3'b110});
      end else begin
        if (off_cnt != 0) off_cnt <= off_cnt - 1'b1;
        if (fd_cnt != 0)  fd_cnt  <= fd_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  chop_state_e state,
  input  logic        phase,
  input  logic        sr_en,
  output logic [3:0]  gates
);
  logic [3:0] want;

  always_comb begin
    case (state)
      ST_DRIVE:          want = phase ? PAT_FWD : PAT_REV;
      ST_FAST, ST_XFAST: want = sr_en ? (phase ? PAT_REV : PAT_FWD) : PAT_OFF;
      ST_SLOW, ST_XSLOW: want = PAT_SLOW;
      default:           want = PAT_OFF;
    endcase
  end

  // a change between two live patterns passes through all-off first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             gates <= PAT_OFF;
    else if (want != gates && gates != '0)  gates <= PAT_OFF;
    else                                    gates <= want;
  end
endmodule

// File: rtl/chopper_core.sv
module chopper_core
  import chop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OFF_W       = 5,
  parameter int FD_W        = 4,
  parameter int DAC_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_raw,
  input  logic             zero_det,
  input  logic             en,
  input  logic             cfg_ready,
  input  logic [1:0]       blank_sel,
  input  logic [OFF_W-1:0] toff_n,
  input  logic [FD_W-1:0]  tfd_n,
  input  logic             int_slow,
  input  logic             ext_slow,
  input  logic             phase,
  input  logic [DAC_W-1:0] dac_code,
  input  logic             sr_en,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl
);
  logic        trip_s;
  logic        active;
  chop_state_e state;
  logic [3:0]  gates;

  assign active = cfg_ready && (dac_code != '0);

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trip_raw), .q(trip_s)
  );

  chop_ctrl #(.OFF_W(OFF_W), .FD_W(FD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .active(active), .trip_s(trip_s),
    .zero_det(zero_det), .en(en), .sr_en(sr_en), .int_slow(int_slow),
    .ext_slow(ext_slow), .blank_sel(blank_sel), .toff_n(toff_n),
    .tfd_n(tfd_n), .state(state)
  );

  chop_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .phase(phase),
    .sr_en(sr_en), .gates(gates)
  );

  assign {gate_ah, gate_al, gate_bh, gate_bl} = gates;
endmodule

// File: rtl/chopper_core_chk.sv
module chopper_core_chk #(
  parameter int DAC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             cfg_ready,
  input logic             phase,
  input logic [DAC_W-1:0] dac_code,
  input logic             gate_ah,
  input logic             gate_al,
  input logic             gate_bh,
  input logic             gate_bl
);
  logic [3:0] g;
  logic [1:0] idle_run, enlow_run;
  logic       phase_q;

  assign g = {gate_ah, gate_al, gate_bh, gate_bl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run  <= '0;
      enlow_run <= '0;
      phase_q   <= 1'b0;
    end else begin
      phase_q <= phase;
      if (cfg_ready && dac_code != '0) idle_run <= '0;
      else if (idle_run != 2'd3)       idle_run <= idle_run + 1'b1;
      if (en || phase != phase_q)      enlow_run <= '0;
      else if (enlow_run != 2'd3)      enlow_run <= enlow_run + 1'b1;
    end
  end

  assert_no_shoot_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah && gate_al));
  assert_no_shoot_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_bh && gate_bl));
  assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (g != 4'b0000) |=> (g == 4'b0000 || g == $past(g)));
  assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run >= 2'd2) |-> (g == 4'b0000));
  assert_no_drive_en_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enlow_run >= 2'd2) |-> (g != (phase ? 4'b1001 : 4'b0110)));
endmodule

bind chopper_core chopper_core_chk #(.DAC_W(DAC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_ready(cfg_ready), .phase(phase),
  .dac_code(dac_code), .gate_ah(gate_ah), .gate_al(gate_al),
  .gate_bh(gate_bh), .gate_bl(gate_bl)
);

// File: tb/test_chopper_core.sv
module test_chopper_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip_raw = 1'b0, zero_det = 1'b0, en = 1'b1, cfg_ready = 1'b0;
  logic [1:0] blank_sel = 2'd0;
  logic [4:0] toff_n = 5'd0;
  logic [3:0] tfd_n = 4'd0;
  logic       int_slow = 1'b0, ext_slow = 1'b0, phase = 1'b1, sr_en = 1'b1;
  logic [3:0] dac_code = 4'd15;
  logic       gate_ah, gate_al, gate_bh, gate_bl;
  logic [3:0] g;
  int total = 0, bad = 0;

  assign g = {gate_ah, gate_al, gate_bh, gate_bl};
  always #2 clk = ~clk;

  chopper_core i_chopper_core (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called on the negedge where a new pattern begins; returns on the next one
  task automatic get_run(output logic [3:0] pat, output int len);
    pat = g; len = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (g != pat) break;
      len++;
    end
  endtask

  task automatic sync_to(input logic [3:0] drv);
    logic [3:0] prev;
    prev = g;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (g == drv && prev == 4'b0000) break;
      prev = g;
    end
  endtask

  task automatic expect_run(input string req, input logic [3:0] pat, input int len);
    logic [3:0] p; int l;
    get_run(p, l);
    chk({req, " pattern"}, p, pat);
    chk({req, " length"}, l, len);
  endtask

  task automatic setup(input logic [1:0] bs, input logic [4:0] to, input logic [3:0] fd,
                       input logic slow, input logic ph, input logic sr, input logic trip);
    @(negedge clk);
    blank_sel = bs; toff_n = to; tfd_n = fd; int_slow = slow; phase = ph;
    sr_en = sr; trip_raw = trip; zero_det = 1'b0; en = 1'b1; ext_slow = 1'b0;
    cfg_ready = 1'b1; dac_code = 4'd9;
    wait_n(120);
  endtask

  task automatic t_reset;
    wait_n(3);
    chk("R10 gates in reset", g, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(6);
    chk("R10 gates before config", g, 0);
  endtask

  task automatic t_blank;
    int blen [4] = '{4, 6, 12, 24};
    for (int s = 0; s < 4; s++) begin
      setup(2'(s), 5'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      sync_to(4'b1001);
      expect_run("R1 blank drive", 4'b1001, blen[s]);
      expect_run("R6 dead gap", 4'b0000, 1);
      expect_run("R2 min off slow", 4'b0101, 6);
    end
  endtask

  task automatic t_sync_latency;
    setup(2'd0, 5'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 steady forward drive", g, 4'b1001);
    trip_raw = 1'b1;
    wait_n(3);
    chk("R1 still driving 3 clocks after trip", g, 4'b1001);
    wait_n(1);
    chk("R1 off 4 clocks after trip", g, 0);
    trip_raw = 1'b0;
  endtask

  task automatic t_mixed_fwd;
    setup(2'd0, 5'd2, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    sync_to(4'b1001);
    expect_run("R5 fwd drive", 4'b1001, 4);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R3 fast decay", 4'b0110, 6);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R2 rest slow", 4'b0101, 15);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R2 drive again", 4'b1001, 4);
  endtask

  task automatic t_fast_fills;
    setup(2'd0, 5'd0, 4'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    sync_to(4'b1001);
    expect_run("R3 drive", 4'b1001, 4);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R3 fast fills off", 4'b0110, 6);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R3 drive after fast", 4'b1001, 4);
  endtask

  task automatic t_reverse;
    setup(2'd0, 5'd2, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    sync_to(4'b0110);
    expect_run("R5 rev drive", 4'b0110, 4);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R5 rev fast", 4'b1001, 6);
  endtask

  task automatic t_slow;
    setup(2'd0, 5'd3, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    sync_to(4'b1001);
    expect_run("R4 drive", 4'b1001, 4);
    expect_run("R6 dead gap", 4'b0000, 1);
    expect_run("R4 slow whole off", 4'b0101, 30);
  endtask

  task automatic t_no_sr;
    setup(2'd0, 5'd2, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    sync_to(4'b1001);
    expect_run("R9 drive", 4'b1001, 4);
    expect_run("R9 diode fast all off", 4'b0000, 7);
    expect_run("R9 slow", 4'b0101, 16);
  endtask

  task automatic t_zero_cut;
    setup(2'd0, 5'd3, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    zero_det = 1'b1;
    sync_to(4'b1001);
    expect_run("R8 drive", 4'b1001, 4);
    expect_run("R8 cut window", 4'b0000, 15);
    expect_run("R8 slow after cut", 4'b0101, 16);
    zero_det = 1'b0;
  endtask

  task automatic t_external;
    setup(2'd0, 5'd2, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    en = 1'b0;
    wait_n(4);
    chk("R7 forced fast", g, 4'b0110);
    ext_slow = 1'b1;
    wait_n(4);
    chk("R7 forced slow", g, 4'b0101);
    ext_slow = 1'b0; zero_det = 1'b1;
    wait_n(4);
    chk("R8 ext zero cut", g, 0);
    wait_n(10);
    chk("R8 ext cut held", g, 0);
    zero_det = 1'b0; en = 1'b1;
    wait_n(3);
    chk("R7 enable rise drives", g, 4'b1001);
  endtask

  task automatic t_disable;
    setup(2'd0, 5'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    dac_code = 4'd0;
    wait_n(3);
    chk("R10 code zero off", g, 0);
    dac_code = 4'd1;
    wait_n(3);
    chk("R10 code restored drives", g, 4'b1001);
    cfg_ready = 1'b0;
    wait_n(3);
    chk("R10 unconfigured off", g, 0);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_blank();
    t_sync_latency();
    t_mixed_fwd();
    t_fast_fills();
    t_reverse();
    t_slow();
    t_no_sr();
    t_zero_cut();
    t_external();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule